// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a read or write burst to a two-bank synchronous DRAM. A one-cycle start strobe captures a start column, a burst length code, a burst ordering, a read/write direction and a single-write mode flag. From the next cycle on, the block presents one column address per clock. It flags each beat as valid and marks the final beat of a fixed-length burst.

A new start may arrive on any cycle and replaces the running burst at once. A stop request also ends the running burst on the next edge. Full-page bursts walk the whole 256-column page, wrapping past the top. They run until a stop or a new start ends them.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `beat_valid` and `last_beat` are 0.
- R2: A start sampled at a clock edge makes the first beat visible from that edge onward, with `col` equal to the captured start column. Further beats follow on each later edge.
- R3: `len_code` 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats, and codes 4 to 6 give a single beat. `last_beat` is 1 only on the final beat, and `beat_valid` is 0 after it unless a new start arrives.
- R4: With `interleave`=0, beat i has the address whose low log2(L) bits are (start + i) mod L and whose upper bits are those of the start column, where L is the burst length.
- R5: With `interleave`=1 and a fixed length, beat i has the address start XOR i.
- R6: `len_code` 7 selects a full-page burst. Beat i has the address (start + i) mod 256 whatever `interleave` is, and `last_beat` is never 1.
- R7: When `single_write`=1, a start with `is_write`=1 gives a single-beat burst whatever the length code, while a start with `is_write`=0 keeps the programmed length. With `single_write`=0, writes keep the programmed length.
- R8: A start during a running burst abandons it. The next beat is the first beat of the new burst.
- R9: A stop without a start ends the running burst, so `beat_valid` is 0 on the next cycle. A stop while idle leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst with the current settings |
| stop | input | 1 | End the running burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code (see R3, R6) |
| interleave | input | 1 | 0 sequential order, 1 interleaved order |
| is_write | input | 1 | 1 for a write burst |
| single_write | input | 1 | Force writes to a single beat |
| col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final one |

## Verification
The embedded properties check the following on every cycle:
- the first beat follows a start and carries its column;
- a stop empties the output next cycle;
- the final beat is followed by idle;
- single-write starts end on their first beat;
- full-page starts never raise `last_beat`.

The address ordering within each burst can only be shown by the bench scenarios, which compare every beat against a queue of expected addresses. These cover sequential wrap inside the aligned block, interleaved XOR order, full-page wrap past column 255, and mid-burst replacement.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             single_write,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             active, full, ilv;
  logic [COL_W-1:0] base, cnt, mask;
  logic [COL_W-1:0] ld_mask;
  logic             ld_full;

  always_comb begin
    ld_full = 1'b0;
    case (len_code)
      3'd1:    ld_mask = COL_W'(1);
      3'd2:    ld_mask = COL_W'(3);
      3'd3:    ld_mask = COL_W'(7);
      3'd7:    begin ld_mask = ALL_ONES; ld_full = 1'b1; end
      default: ld_mask = '0;
    endcase
    if (is_write && single_write) begin
      ld_mask = '0;
      ld_full = 1'b0;
    end
  end

  assign col        = ilv ? (base ^ cnt) : ((base & ~mask) | ((base + cnt) & mask));
  assign beat_valid = active;
  assign last_beat  = active && !full && (cnt == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      full   <= 1'b0;
      ilv    <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask   <= '0;
    end else if (start) begin
      active <= 1'b1;
      full   <= ld_full;
      ilv    <= interleave && !ld_full;
      base   <= start_col;
      cnt    <= '0;
      mask   <= ld_mask;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active) begin
      if (last_beat) active <= 1'b0;
      else           cnt    <= cnt + 1'b1;
    end
  end

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_valid && col == $past(start_col)); // R2
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid); // R3
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && !start |=> !beat_valid); // R3
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_code == 3'd7 && !(is_write && single_write) |=> !last_beat); // R6
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start && is_write && single_write |=> last_beat); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !beat_valid); // R9
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0, is_write = 1'b0, single_write = 1'b0;
  logic [7:0] col;
  logic       beat_valid, last_beat;

  int checks = 0;
  int errors = 0;
  logic [8:0] expq[$];
  string      tagq[$];

  always #(PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .is_write(is_write),
    .single_write(single_write), .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
  );

  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL beat with empty queue R2: col=%0h last=%0b expected no beat", col, last_beat);
      end else begin
        logic [8:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({last_beat, col} !== e) begin
          errors++;
          $display("FAIL %s: last/col=%0b/%0h expected %0b/%0h", t, last_beat, col, e[8], e[7:0]);
        end
      end
    end
  end

  task automatic chk_idle(input string tag);
    checks++;
    if (beat_valid !== 1'b0 || last_beat !== 1'b0) begin
      errors++;
      $display("FAIL %s: valid/last=%0b/%0b expected 0/0", tag, beat_valid, last_beat);
    end
  endtask

  task automatic go(input logic [7:0] c, input logic [2:0] code, input logic ilv,
                    input logic wr, input logic sw, input int keep, input bit do_stop,
                    input string tag);
    int  len, n;
    bit  fullp;
    fullp = (code == 3'd7) && !(wr && sw);
    case (code)
      3'd1: len = 2;
      3'd2: len = 4;
      3'd3: len = 8;
      3'd7: len = 256;
      default: len = 1;
    endcase
    if (wr && sw) len = 1;
    n = (fullp || keep < len) ? keep : len;
    start_col = c; len_code = code; interleave = ilv; is_write = wr; single_write = sw;
    start = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      if (fullp)    a = 8'(int'(c) + i);
      else if (ilv) a = c ^ 8'(i);
      else          a = 8'(int'(c) - (int'(c) % len) + ((int'(c) % len + i) % len));
      expq.push_back({(!fullp && i == len - 1), a});
      tagq.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (n - 1) @(negedge clk);
    if (do_stop) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk_idle({tag, " stop"});
    end
  endtask

  task automatic idle_next(input string tag);
    @(negedge clk);
    chk_idle(tag);
  endtask

  task automatic finish_run();
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 missing beats: left=%0d expected 0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R2: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 after reset");

    go(8'h0D, 3'd2, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R4 seq BL4");  idle_next("R3 end BL4");
    go(8'h21, 3'd1, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R4 seq BL2");  idle_next("R3 end BL2");
    go(8'h5B, 3'd3, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R4 seq BL8");  idle_next("R3 end BL8");
    go(8'h35, 3'd3, 1'b1, 1'b0, 1'b0, 99, 1'b0, "R5 ilv BL8");  idle_next("R3 end ilv BL8");
    go(8'h46, 3'd2, 1'b1, 1'b0, 1'b0, 99, 1'b0, "R5 ilv BL4");  idle_next("R3 end ilv BL4");
    go(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R3 BL1");      idle_next("R3 end BL1");
    go(8'h12, 3'd5, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R3 code5");    idle_next("R3 end code5");
    go(8'hFC, 3'd7, 1'b1, 1'b0, 1'b0, 10, 1'b1, "R6 full page wrap");
    go(8'h80, 3'd7, 1'b0, 1'b0, 1'b0, 300, 1'b1, "R6 full page long");
    go(8'h93, 3'd3, 1'b0, 1'b1, 1'b1, 99, 1'b0, "R7 write single"); idle_next("R7 end write single");
    go(8'h93, 3'd2, 1'b0, 1'b0, 1'b1, 99, 1'b0, "R7 read keeps");  idle_next("R7 end read");
    go(8'h93, 3'd2, 1'b0, 1'b1, 1'b0, 99, 1'b0, "R7 write normal"); idle_next("R7 end write normal");
    go(8'h40, 3'd3, 1'b0, 1'b0, 1'b0, 3, 1'b0, "R8 interrupted");
    go(8'hA7, 3'd1, 1'b0, 1'b0, 1'b0, 1, 1'b0, "R8 interrupted again");
    go(8'h10, 3'd2, 1'b1, 1'b0, 1'b0, 99, 1'b0, "R8 replacing"); idle_next("R8 end");
    go(8'h08, 3'd3, 1'b0, 1'b0, 1'b0, 2, 1'b1, "R9 stop mid BL8");
    idle_next("R9 stays idle");
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk_idle("R9 stop while idle");
    idle_next("R9 idle after idle stop");
    finish_run();
  end
endmodule